// File: doc/BRIEF.md
# SMBus Host Register File

This block is the software-visible register set of an SMBus host controller, reached through a 16-byte I/O window. It has a status register, a control register, a command byte, a target address byte, two data bytes and a 32-byte block buffer. The block buffer sits behind a single data port. A shared 5-bit pointer selects the buffer entry for each access and steps forward after every access.

The block does not drive the SMBus wires and does not run transactions. A write to the control register is recorded, and the block raises a one-cycle `startPulse` so that a separate engine can act on it. The window can be reached when the I/O-space enable or the separate host enable is set. When both enables are clear, reads return all ones and writes are dropped.

Reads have side effects, because they can move the buffer pointer. For this reason read data is registered: it appears on `rdData` together with `rdValid` in the cycle after `rdEn`.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset, every register, the buffer pointer and all 32 buffer bytes are zero, and `rdValid` and `startPulse` are low.
- R2: A read accepted at a clock edge sets `rdValid` high for exactly the following cycle, with the data on `rdData`. No read request means `rdValid` is low.
- R3: Writes to offsets 0x3 (command), 0x4 (target address), 0x5 (data byte 0) and 0x6 (data byte 1) store the written byte, and later reads return it.
- R4: A permitted write to offset 0x2 (control) raises `startPulse` for the single cycle after the write. No other access raises it.
- R5: A read of offset 0x2 returns only the low 5 bits of control, with bits 7:5 reading as 0. The read also sets the buffer pointer back to 0.
- R6: A write of any value to offset 0x0 (status) clears status and sets the buffer pointer back to 0. Status reads as 0.
- R7: Each read or write of offset 0x7 accesses the buffer entry at the pointer and then increments the pointer. Reads and writes share the same pointer.
- R8: After entry 31 the pointer wraps to entry 0.
- R9: Reads of offset 0x1 and offsets 0x8 to 0xF return 0. Writes to those offsets change no register.
- R10: When both `ioSpaceEn` and `hostEn` are low, reads return 0xFF. Writes are ignored, and the pointer does not move.
- R11: Either enable alone is enough to allow access.
- R12: When `wrEn` and `rdEn` are high in the same cycle, only the write is carried out, and no `rdValid` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioSpaceEn | input | 1 | I/O-space enable from configuration |
| hostEn | input | 1 | Separate host enable from configuration |
| wrEn | input | 1 | Register write request |
| rdEn | input | 1 | Register read request |
| addr | input | 4 | Offset within the window |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| startPulse | output | 1 | One-cycle pulse after a control write |

## Verification
The bench writes 34 block bytes to push the pointer past entry 31. It then reads them back and expects entries 0 and 1 to hold the overwritten values; a design without the wrap would read from the wrong entry or from unknown storage. It interleaves block reads with a control read and a status write to confirm that both rewind the shared pointer. A design that rewound on the wrong access, or kept separate read and write pointers, would return bytes in the wrong order. With both enables low, it makes accesses that must neither change data nor move the pointer, and checks the all-ones read value. Finally, it issues a read and a write in the same cycle and expects no read response.

// File: rtl/smbus_host_pkg.sv
package smbus_host_pkg;

  // Offsets within the window; software decodes these.
  localparam int unsigned OFS_STAT = 0;
  localparam int unsigned OFS_CTRL = 2;
  localparam int unsigned OFS_CMD  = 3;
  localparam int unsigned OFS_ADDR = 4;
  localparam int unsigned OFS_D0   = 5;
  localparam int unsigned OFS_D1   = 6;
  localparam int unsigned OFS_BLK  = 7;

  typedef enum logic [3:0] {
    SEL_ZERO,
    SEL_ONES,
    SEL_STAT,
    SEL_CTRL,
    SEL_CMD,
    SEL_ADDR,
    SEL_D0,
    SEL_D1,
    SEL_BLK
  } rdSel_e;

  // Strobes from control decode to the datapath.
  typedef struct packed {
    logic   wrStat;
    logic   wrCtrl;
    logic   wrCmd;
    logic   wrAddr;
    logic   wrD0;
    logic   wrD1;
    logic   wrBlk;
    logic   rdFire;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/smbus_host_ctrl.sv
module smbus_host_ctrl
  import smbus_host_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              ioSpaceEn,
  input  logic              hostEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobes_t          st
);

  logic accessOk;
  assign accessOk = ioSpaceEn | hostEn;

  always_comb begin
    st       = '0;
    st.rdSel = SEL_ZERO;
    if (wrEn) begin
      // A write wins; a read asserted in the same cycle is dropped.
      if (accessOk) begin
        case (addr)
          ADDR_W'(OFS_STAT): st.wrStat = 1'b1;
          ADDR_W'(OFS_CTRL): st.wrCtrl = 1'b1;
          ADDR_W'(OFS_CMD):  st.wrCmd  = 1'b1;
          ADDR_W'(OFS_ADDR): st.wrAddr = 1'b1;
          ADDR_W'(OFS_D0):   st.wrD0   = 1'b1;
          ADDR_W'(OFS_D1):   st.wrD1   = 1'b1;
          ADDR_W'(OFS_BLK):  st.wrBlk  = 1'b1;
          default: ;
        endcase
      end
    end else if (rdEn) begin
      st.rdFire = 1'b1;
      if (!accessOk) begin
        st.rdSel = SEL_ONES;
      end else begin
        case (addr)
          ADDR_W'(OFS_STAT): st.rdSel = SEL_STAT;
          ADDR_W'(OFS_CTRL): st.rdSel = SEL_CTRL;
          ADDR_W'(OFS_CMD):  st.rdSel = SEL_CMD;
          ADDR_W'(OFS_ADDR): st.rdSel = SEL_ADDR;
          ADDR_W'(OFS_D0):   st.rdSel = SEL_D0;
          ADDR_W'(OFS_D1):   st.rdSel = SEL_D1;
          ADDR_W'(OFS_BLK):  st.rdSel = SEL_BLK;
          default:           st.rdSel = SEL_ZERO;
        endcase
      end
    end
  end

endmodule

// File: rtl/smbus_host_dp.sv
module smbus_host_dp
  import smbus_host_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BUF_DEPTH = 32,
  parameter int CTRL_RD_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              startPulse
);

  localparam int IDX_W = $clog2(BUF_DEPTH);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BUF_DEPTH - 1);

  logic [DATA_W-1:0]    statReg;
  logic [CTRL_RD_W-1:0] ctrlReg;
  logic [DATA_W-1:0]    cmdReg;
  logic [DATA_W-1:0]    tgtReg;
  logic [DATA_W-1:0]    d0Reg;
  logic [DATA_W-1:0]    d1Reg;
  logic [IDX_W-1:0]     blkIdx;
  logic [IDX_W-1:0]     blkIdxBump;
  logic [DATA_W-1:0]    blkMem [BUF_DEPTH];
  logic [DATA_W-1:0]    rdMux;
  logic                 rewind;
  logic                 advance;

  assign blkIdxBump = (blkIdx == IDX_LAST) ? '0 : blkIdx + 1'b1;
  assign rewind  = st.wrStat | (st.rdFire & (st.rdSel == SEL_CTRL));
  assign advance = st.wrBlk  | (st.rdFire & (st.rdSel == SEL_BLK));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReg <= '0;
      ctrlReg <= '0;
      cmdReg  <= '0;
      tgtReg  <= '0;
      d0Reg   <= '0;
      d1Reg   <= '0;
    end else begin
      if (st.wrStat) statReg <= '0;
      if (st.wrCtrl) ctrlReg <= wrData[CTRL_RD_W-1:0];
      if (st.wrCmd)  cmdReg  <= wrData;
      if (st.wrAddr) tgtReg  <= wrData;
      if (st.wrD0)   d0Reg   <= wrData;
      if (st.wrD1)   d1Reg   <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        blkIdx <= '0;
    else if (rewind)  blkIdx <= '0;
    else if (advance) blkIdx <= blkIdxBump;
  end

  for (genvar e = 0; e < BUF_DEPTH; e++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN)
        blkMem[e] <= '0;
      else if (st.wrBlk && (blkIdx == IDX_W'(e)))
        blkMem[e] <= wrData;
    end
  end

  always_comb begin
    case (st.rdSel)
      SEL_ONES: rdMux = '1;
      SEL_STAT: rdMux = statReg;
      SEL_CTRL: rdMux = {{(DATA_W-CTRL_RD_W){1'b0}}, ctrlReg};
      SEL_CMD:  rdMux = cmdReg;
      SEL_ADDR: rdMux = tgtReg;
      SEL_D0:   rdMux = d0Reg;
      SEL_D1:   rdMux = d1Reg;
      SEL_BLK:  rdMux = blkMem[blkIdx];
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData     <= '0;
      rdValid    <= 1'b0;
      startPulse <= 1'b0;
    end else begin
      rdValid    <= st.rdFire;
      startPulse <= st.wrCtrl;
      if (st.rdFire) rdData <= rdMux;
    end
  end

endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
  import smbus_host_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int BUF_DEPTH = 32,
  parameter int CTRL_RD_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioSpaceEn,
  input  logic              hostEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              startPulse
);

  strobes_t st;

  smbus_host_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .ioSpaceEn(ioSpaceEn),
    .hostEn   (hostEn),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .addr     (addr),
    .st       (st)
  );

  smbus_host_dp #(
    .DATA_W   (DATA_W),
    .BUF_DEPTH(BUF_DEPTH),
    .CTRL_RD_W(CTRL_RD_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .wrData    (wrData),
    .rdData    (rdData),
    .rdValid   (rdValid),
    .startPulse(startPulse)
  );

endmodule

// File: rtl/smbus_host_regs_chk.sv
module smbus_host_regs_chk #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CTRL_RD_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              ioSpaceEn,
  input logic              hostEn,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              startPulse
);

  logic ok;
  logic rdGo;
  logic unimpl;
  assign ok     = ioSpaceEn | hostEn;
  assign rdGo   = rdEn & ~wrEn;
  assign unimpl = (addr == ADDR_W'(1)) || (addr > ADDR_W'(7));

  assert_rd_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdGo |=> rdValid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rdGo |=> !rdValid);
  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ok && addr == ADDR_W'(2)) |=> startPulse);
  assert_no_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && ok && addr == ADDR_W'(2)) |=> !startPulse);
  assert_ctrl_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdGo && ok && addr == ADDR_W'(2)) |=> (rdData[DATA_W-1:CTRL_RD_W] == '0));
  assert_stat_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdGo && ok && addr == ADDR_W'(0)) |=> (rdData == '0));
  assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdGo && ok && unimpl) |=> (rdData == '0));
  assert_blocked_ones_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdGo && !ok) |=> (rdData == '1));
  assert_both_drop_R12: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdEn) |=> !rdValid);

  logic unusedBits;
  assign unusedBits = ^wrData;

endmodule

bind smbus_host_regs smbus_host_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_RD_W(CTRL_RD_W)
) chk_i (.*);

// File: tb/smbus_host_regs_tb_top.sv
`timescale 1ns/1ps
module smbus_host_regs_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ioSpaceEn = 1'b0;
  logic       hostEn = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       rdValid;
  logic       startPulse;

  always #2.5 clk = ~clk;

  smbus_host_regs dut_i (
    .clk(clk), .rstN(rstN), .ioSpaceEn(ioSpaceEn), .hostEn(hostEn),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .startPulse(startPulse)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Reference state of the register file.
  logic [7:0] mCtrl, mCmd, mTgt, mD0, mD1;
  logic [7:0] mBuf [32];
  int         mIdx;

  logic [7:0] expQ [$];
  string      tagQ [$];

  function automatic bit okNow();
    return ioSpaceEn | hostEn;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Monitor: compares each read response against the queued expectation.
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R12 actual=unexpected rdValid expected=none");
      end else begin
        check(tagQ.pop_front(), rdData, expQ.pop_front());
      end
    end
  end

  task automatic doWrite(int a, logic [7:0] d);
    bit isCtrl;
    isCtrl = okNow() && (a == 2);
    if (okNow()) begin
      case (a)
        0: mIdx = 0;
        2: mCtrl = d;
        3: mCmd = d;
        4: mTgt = d;
        5: mD0 = d;
        6: mD1 = d;
        7: begin mBuf[mIdx] = d; mIdx = (mIdx + 1) % 32; end
        default: ;
      endcase
    end
    wrEn = 1'b1; addr = 4'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    check("R4 startPulse", {7'b0, startPulse}, {7'b0, isCtrl});
  endtask

  task automatic doRead(int a, string tag);
    logic [7:0] e;
    if (!okNow()) e = 8'hFF;
    else begin
      case (a)
        0: e = 8'h00;
        2: begin e = mCtrl & 8'h1F; mIdx = 0; end
        3: e = mCmd;
        4: e = mTgt;
        5: e = mD0;
        6: e = mD1;
        7: begin e = mBuf[mIdx]; mIdx = (mIdx + 1) % 32; end
        default: e = 8'h00;
      endcase
    end
    expQ.push_back(e); tagQ.push_back(tag);
    rdEn = 1'b1; addr = 4'(a);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mCtrl = 0; mCmd = 0; mTgt = 0; mD0 = 0; mD1 = 0; mIdx = 0;
    for (int i = 0; i < 32; i++) mBuf[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rdValid", {7'b0, rdValid}, 8'h00);
    check("R1 startPulse", {7'b0, startPulse}, 8'h00);
    ioSpaceEn = 1'b1;

    // R1 / R9: every offset reads zero after reset
    for (int a = 0; a < 16; a++) doRead(a, (a == 1 || a > 7) ? "R9 unimpl" : "R1 reset");
    doWrite(0, 8'hA5);                        // R6 rewind

    // R3
    doWrite(3, 8'h3C); doWrite(4, 8'hB7); doWrite(5, 8'h01); doWrite(6, 8'hFE);
    doRead(3, "R3 cmd"); doRead(4, "R3 addr"); doRead(5, "R3 d0"); doRead(6, "R3 d1");

    // R4 / R5
    doWrite(2, 8'hFF);
    doRead(2, "R5 ctrl low bits");
    doWrite(2, 8'h4A);
    doRead(2, "R5 ctrl low bits");

    // R7 / R8: fill 32 entries then two more to wrap
    doWrite(0, 8'h00);
    for (int i = 0; i < 34; i++) doWrite(7, 8'(i * 7 + 3));
    doWrite(0, 8'hFF);                        // R6 rewind
    for (int i = 0; i < 34; i++) doRead(7, (i >= 32) ? "R8 wrap" : "R7 block");

    // R5 rewind via control read, R6 rewind via status write
    doRead(7, "R7 block"); doRead(7, "R7 block"); doRead(7, "R7 block");
    doRead(2, "R5 ctrl");
    doRead(7, "R5 rewind");
    doWrite(7, 8'h99); doWrite(7, 8'h98);
    doWrite(0, 8'h12);
    doRead(7, "R6 rewind"); doRead(7, "R7 shared idx");
    doRead(0, "R6 status");

    // R10: blocked access
    ioSpaceEn = 1'b0; hostEn = 1'b0;
    doWrite(3, 8'h55); doWrite(7, 8'h66); doWrite(2, 8'h11); doWrite(0, 8'h00);
    doRead(3, "R10 ones"); doRead(7, "R10 ones"); doRead(2, "R10 ones");
    ioSpaceEn = 1'b1;
    doRead(3, "R10 write ignored"); doRead(7, "R10 idx held");

    // R11: host enable alone
    ioSpaceEn = 1'b0; hostEn = 1'b1;
    doWrite(5, 8'h77);
    doRead(5, "R11 host enable");
    hostEn = 1'b0; ioSpaceEn = 1'b1;

    // R9: writes to unimplemented offsets change nothing
    doWrite(1, 8'hEE); doWrite(8, 8'hDD); doWrite(15, 8'hCC);
    doRead(3, "R9 no effect"); doRead(4, "R9 no effect"); doRead(6, "R9 no effect");
    doRead(7, "R9 idx held"); doRead(15, "R9 unimpl"); doRead(1, "R9 unimpl");

    // R12: simultaneous read and write
    mD1 = 8'h42;
    wrEn = 1'b1; rdEn = 1'b1; addr = 4'd6; wrData = 8'h42;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R12 no rdValid", {7'b0, rdValid}, 8'h00);
    doRead(6, "R12 write applied");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      total++; bad++;
      $display("FAIL R2 actual=%0d pending expected=0", expQ.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule